// File: doc/BRIEF.md
# Auto-Ranging Speed Capture Timer

This block measures the time between speed-sensor events with a counter whose time base is a power-of-two division of a source tick. The division ratio is managed by the block itself. When the counter would run past its all-ones value, the ratio goes up by one and the running count is halved, so the measurement stays in range. When a captured period comes out small, the ratio goes down by one and the captured value is doubled, so precision is restored. Both directions stop at their limits, and each automatic step raises a sticky flag.

Two sensor families are supported. With a tachogenerator or Hall sensor, the source tick is every cycle of the peripheral clock, and a capture fires on the sensor's active edge. With an encoder, the source tick is the encoder clock, and the capture comes from one of two places: a strobe signalling a read of the counter's upper byte, or a periodic real-time tick. After every capture the counter restarts from zero.

Top module: `spdcap_top`

## Requirements
- R1: After reset the captured value, ratio, both flags and the interrupt are all zero.
- R2: In tacho mode (sensor_sel = 0) the counter advances once every 2^ratio clock cycles counted from the last capture or ratio change. A tacho_edge pulse latches the count into cap_value and restarts the count at zero.
- R3: An enabled count step at the all-ones value with ratio below its maximum raises the ratio by one, halves the count (right shift by one) and sets up_flag.
- R4: A capture whose value is below LOW_LIMIT while the ratio is above zero lowers the ratio by one, stores the value shifted left by one, and sets dn_flag.
- R5: At ratio zero a small capture is stored unshifted, the ratio stays zero and dn_flag is not set.
- R6: At the maximum ratio the count holds at all-ones instead of stepping, with no ratio change and no up_flag. A capture then returns all-ones.
- R7: If a capture and an overflow step fall in the same cycle, the overflow is handled first and the capture stores the halved count.
- R8: In encoder mode (sensor_sel = 1) the counter advances on enc_tick pulses only, and tacho_edge has no effect.
- R9: In encoder mode with trig_mode = 1, hi_read triggers a capture and rtc_tick is ignored. With trig_mode = 0, rtc_tick triggers a capture and hi_read is ignored.
- R10: clr_up and clr_dn clear their flag on a one-cycle strobe; a flag that is set in the same cycle as its clear stays set.
- R11: irq equals (up_flag OR dn_flag) AND irq_mask.
- R12: A capture exactly equal to LOW_LIMIT is stored unchanged and leaves the ratio alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| sensor_sel | input | 1 | 0 = tacho/Hall, 1 = encoder |
| tacho_edge | input | 1 | One-cycle pulse on the active sensor edge |
| enc_tick | input | 1 | One-cycle pulse per encoder clock |
| trig_mode | input | 1 | Encoder capture source: 1 = upper-byte read, 0 = real-time tick |
| hi_read | input | 1 | Strobe for a read of the counter's upper byte |
| rtc_tick | input | 1 | Periodic real-time tick |
| irq_mask | input | 1 | Interrupt enable |
| clr_up | input | 1 | Write-one-to-clear strobe for up_flag |
| clr_dn | input | 1 | Write-one-to-clear strobe for dn_flag |
| cap_value | output | CNT_W | Last captured, range-adjusted period |
| ratio | output | RATIO_W | Current prescaler exponent |
| up_flag | output | 1 | Sticky: ratio raised automatically |
| dn_flag | output | 1 | Sticky: ratio lowered automatically |
| irq | output | 1 | Masked OR of the two flags |

## Verification
A wrong ratio shows up on the ratio port within one cycle and skews every later capture by a factor of two per step, so a single capture after a known idle span exposes it. A wrong count or divider phase is invisible until the next capture, which then reads off by the exact number of lost or extra steps. Saturation faults appear only after the ratio reaches its top, so the bench runs a reduced-width instance there and checks that the held all-ones value and the quiet up_flag persist over a long idle span.

// File: rtl/spdcap_pkg.sv
package spdcap_pkg;
  typedef enum logic {SENSE_TACHO = 1'b0, SENSE_ENCODER = 1'b1} sense_e;
  typedef enum logic {TRIG_RTC = 1'b0, TRIG_READ = 1'b1} etrig_e;
endpackage

// File: rtl/spdcap_trig.sv
module spdcap_trig
  import spdcap_pkg::*;
(
  input  logic sensor_sel,
  input  logic trig_mode,
  input  logic tacho_edge,
  input  logic enc_tick,
  input  logic hi_read,
  input  logic rtc_tick,
  output logic src_tick,
  output logic cap_fire
);
  sense_e sense;
  etrig_e etrig;

  always_comb begin
    sense = sense_e'(sensor_sel);
    etrig = etrig_e'(trig_mode);
    if (sense == SENSE_TACHO) begin
      src_tick = 1'b1;
      cap_fire = tacho_edge;
    end else begin
      src_tick = enc_tick;
      cap_fire = (etrig == TRIG_READ) ? hi_read : rtc_tick;
    end
  end
endmodule

// File: rtl/spdcap_presc.sv
module spdcap_presc #(
  parameter int RATIO_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               src_tick,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               restart,
  output logic               cnt_en
);
  localparam int DIV_W = (1 << RATIO_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  always_comb begin
    mask   = ~({DIV_W{1'b1}} << ratio);
    cnt_en = src_tick && (div_q == mask);
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      div_q <= '0;
    end else if (src_tick) begin
      if (div_q == mask) div_q <= '0;
      else               div_q <= div_q + DIV_W'(1);
    end
  end

  // R2
  en_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && ratio != '0 && !restart) |=> !cnt_en);
endmodule

// File: rtl/spdcap_range.sv
module spdcap_range #(
  parameter int               CNT_W     = 16,
  parameter int               RATIO_W   = 4,
  parameter logic [CNT_W-1:0] LOW_LIMIT = CNT_W'(16'h5500)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cnt_en,
  input  logic               cap_fire,
  input  logic               clr_up,
  input  logic               clr_dn,
  output logic               restart,
  output logic [RATIO_W-1:0] ratio,
  output logic [CNT_W-1:0]   cap_value,
  output logic               up_flag,
  output logic               dn_flag
);
  localparam logic [RATIO_W-1:0] RMAX = '1;

  logic [CNT_W-1:0]   cnt_q, cnt_d, cap_q, cap_d, adj;
  logic [RATIO_W-1:0] ratio_q, ratio_d, ratio_a;
  logic               up_q, dn_q, at_top, grow, shrink;

  always_comb begin
    at_top  = (cnt_q == '1);
    grow    = cnt_en && at_top && (ratio_q != RMAX);
    ratio_a = grow ? ratio_q + RATIO_W'(1) : ratio_q;
    adj     = grow ? (cnt_q >> 1) : cnt_q;
    shrink  = cap_fire && (adj < LOW_LIMIT) && (ratio_a != '0);
    restart = cap_fire || grow;

    cnt_d   = cnt_q;
    cap_d   = cap_q;
    ratio_d = ratio_a;
    if (cap_fire) begin
      cnt_d = '0;
      cap_d = shrink ? (adj << 1) : adj;
      if (shrink) ratio_d = ratio_a - RATIO_W'(1);
    end else if (grow) begin
      cnt_d = adj;
    end else if (cnt_en && !at_top) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      cap_q   <= '0;
      ratio_q <= '0;
      up_q    <= 1'b0;
      dn_q    <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      cap_q   <= cap_d;
      ratio_q <= ratio_d;
      up_q    <= grow   || (up_q && !clr_up);
      dn_q    <= shrink || (dn_q && !clr_dn);
    end
  end

  assign ratio     = ratio_q;
  assign cap_value = cap_q;
  assign up_flag   = up_q;
  assign dn_flag   = dn_q;

  // R3
  ratio_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ratio_q != $past(ratio_q)) |->
      (ratio_q == $past(ratio_q) + RATIO_W'(1) || ratio_q == $past(ratio_q) - RATIO_W'(1)));

  // R4
  shrink_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dn_q) |-> (cap_q[0] == 1'b0 && ratio_q == $past(ratio_q) - RATIO_W'(1)));

  // R5
  floor_chk: assert property (@(posedge clk) disable iff (rst)
    (ratio_q == '0 && !(cnt_en && cnt_q == '1)) |=> ratio_q == '0);

  // R6
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ratio_q == RMAX && cnt_q == '1 && !cap_fire) |=> (cnt_q == '1 && ratio_q == RMAX && !$rose(up_q)));
endmodule

// File: rtl/spdcap_top.sv
module spdcap_top #(
  parameter int               CNT_W     = 16,
  parameter int               RATIO_W   = 4,
  parameter logic [CNT_W-1:0] LOW_LIMIT = CNT_W'(16'h5500)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sensor_sel,
  input  logic               tacho_edge,
  input  logic               enc_tick,
  input  logic               trig_mode,
  input  logic               hi_read,
  input  logic               rtc_tick,
  input  logic               irq_mask,
  input  logic               clr_up,
  input  logic               clr_dn,
  output logic [CNT_W-1:0]   cap_value,
  output logic [RATIO_W-1:0] ratio,
  output logic               up_flag,
  output logic               dn_flag,
  output logic               irq
);
  logic src_tick, cap_fire, cnt_en, restart;

  spdcap_trig u_trig (
    .sensor_sel (sensor_sel),
    .trig_mode  (trig_mode),
    .tacho_edge (tacho_edge),
    .enc_tick   (enc_tick),
    .hi_read    (hi_read),
    .rtc_tick   (rtc_tick),
    .src_tick   (src_tick),
    .cap_fire   (cap_fire)
  );

  spdcap_presc #(.RATIO_W(RATIO_W)) u_presc (
    .clk      (clk),
    .rst      (rst),
    .src_tick (src_tick),
    .ratio    (ratio),
    .restart  (restart),
    .cnt_en   (cnt_en)
  );

  spdcap_range #(.CNT_W(CNT_W), .RATIO_W(RATIO_W), .LOW_LIMIT(LOW_LIMIT)) u_range (
    .clk       (clk),
    .rst       (rst),
    .cnt_en    (cnt_en),
    .cap_fire  (cap_fire),
    .clr_up    (clr_up),
    .clr_dn    (clr_dn),
    .restart   (restart),
    .ratio     (ratio),
    .cap_value (cap_value),
    .up_flag   (up_flag),
    .dn_flag   (dn_flag)
  );

  assign irq = irq_mask && (up_flag || dn_flag);

  // R11
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_mask |-> !irq);
endmodule

// File: tb/tb_spdcap_top.sv
module tb_spdcap_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;
  localparam int RW = 3;
  localparam logic [CW-1:0] LOW = 8'h55;
  localparam logic [RW-1:0] RTOP = 3'd7;

  logic clk = 1'b0;
  logic rst, sensor_sel, tacho_edge, enc_tick, trig_mode, hi_read, rtc_tick;
  logic irq_mask, clr_up, clr_dn;
  logic [CW-1:0] cap_value;
  logic [RW-1:0] ratio;
  logic up_flag, dn_flag, irq;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spdcap_top #(.CNT_W(CW), .RATIO_W(RW), .LOW_LIMIT(LOW)) dut (
    .clk(clk), .rst(rst), .sensor_sel(sensor_sel), .tacho_edge(tacho_edge),
    .enc_tick(enc_tick), .trig_mode(trig_mode), .hi_read(hi_read),
    .rtc_tick(rtc_tick), .irq_mask(irq_mask), .clr_up(clr_up), .clr_dn(clr_dn),
    .cap_value(cap_value), .ratio(ratio), .up_flag(up_flag), .dn_flag(dn_flag),
    .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tacho_pulse();
    tacho_edge = 1'b1; @(negedge clk); tacho_edge = 1'b0;
  endtask

  task automatic strobe_clear();
    clr_up = 1'b1; clr_dn = 1'b1; @(negedge clk); clr_up = 1'b0; clr_dn = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; idle(3); rst = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 cap_value", int'(cap_value), 0);
    chk("R1 ratio", int'(ratio), 0);
    chk("R1 flags", int'({up_flag, dn_flag, irq}), 0);
  endtask

  task automatic t_ratio0();
    tacho_pulse(); idle(10); tacho_pulse();
    chk("R2 capture at ratio 0", int'(cap_value), 10);
    chk("R5 no shift at ratio 0", int'(ratio), 0);
    chk("R5 no dn_flag", int'(dn_flag), 0);
  endtask

  task automatic t_overflow();
    tacho_pulse(); idle(256);
    chk("R3 ratio raised", int'(ratio), 1);
    chk("R3 up_flag", int'(up_flag), 1);
    chk("R11 irq with mask", int'(irq), 1);
    tacho_pulse();
    chk("R3 halved count captured", int'(cap_value), 'h7F);
  endtask

  task automatic t_clear_mask();
    irq_mask = 1'b0; @(negedge clk);
    chk("R11 irq masked", int'(irq), 0);
    irq_mask = 1'b1;
    clr_up = 1'b1; @(negedge clk); clr_up = 1'b0;
    chk("R10 up_flag cleared", int'(up_flag), 0);
    chk("R11 irq drops with flags", int'(irq), 0);
  endtask

  task automatic t_shrink();
    tacho_pulse(); idle(20); tacho_pulse();
    chk("R2 ratio 1 period, R4 doubled", int'(cap_value), 'h14);
    chk("R4 ratio lowered", int'(ratio), 0);
    chk("R4 dn_flag", int'(dn_flag), 1);
  endtask

  task automatic t_threshold();
    tacho_pulse(); idle(256);
    chk("R3 back at ratio 1", int'(ratio), 1);
    tacho_pulse(); idle(170); tacho_pulse();
    chk("R12 value at limit kept", int'(cap_value), 'h55);
    chk("R12 ratio kept", int'(ratio), 1);
    idle(168); tacho_pulse();
    chk("R4 one below limit doubled", int'(cap_value), 'hA8);
    chk("R4 ratio lowered again", int'(ratio), 0);
  endtask

  task automatic t_same_cycle();
    strobe_clear();
    chk("R10 both flags cleared", int'({up_flag, dn_flag}), 0);
    tacho_pulse(); idle(255);
    tacho_edge = 1'b1; clr_up = 1'b1; @(negedge clk); tacho_edge = 1'b0; clr_up = 1'b0;
    chk("R7 capture sees halved count", int'(cap_value), 'h7F);
    chk("R7 ratio raised", int'(ratio), 1);
    chk("R10 set wins over clear", int'(up_flag), 1);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 40000 && ratio != RTOP; i++) @(negedge clk);
    chk("R3 climbs to top ratio", int'(ratio), int'(RTOP));
    clr_up = 1'b1; @(negedge clk); clr_up = 1'b0;
    idle(20000);
    chk("R6 ratio stays at top", int'(ratio), int'(RTOP));
    chk("R6 no up_flag at top", int'(up_flag), 0);
    tacho_pulse();
    chk("R6 capture returns all-ones", int'(cap_value), 'hFF);
    idle(10); tacho_pulse();
    chk("R4 step down from top", int'(ratio), int'(RTOP) - 1);
  endtask

  task automatic enc_ticks(input int n, input bit rtc_noise);
    repeat (n) begin
      enc_tick = 1'b1; tacho_edge = 1'b1; @(negedge clk);
      enc_tick = 1'b0; tacho_edge = 1'b0; rtc_tick = rtc_noise; @(negedge clk);
      rtc_tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic t_encoder();
    do_reset();
    sensor_sel = 1'b1; trig_mode = 1'b1;
    hi_read = 1'b1; @(negedge clk); hi_read = 1'b0;
    enc_ticks(5, 1'b1);
    hi_read = 1'b1; @(negedge clk); hi_read = 1'b0;
    chk("R8 R9 encoder count on read", int'(cap_value), 5);
    trig_mode = 1'b0;
    enc_ticks(7, 1'b0);
    hi_read = 1'b1; @(negedge clk); hi_read = 1'b0;
    chk("R9 read ignored in tick mode", int'(cap_value), 5);
    rtc_tick = 1'b1; @(negedge clk); rtc_tick = 1'b0;
    chk("R9 rtc capture", int'(cap_value), 7);
  endtask

  initial begin
    rst = 1'b1; sensor_sel = 1'b0; tacho_edge = 1'b0; enc_tick = 1'b0;
    trig_mode = 1'b0; hi_read = 1'b0; rtc_tick = 1'b0; irq_mask = 1'b1;
    clr_up = 1'b0; clr_dn = 1'b0;
    @(negedge clk);
    do_reset();
    t_reset();
    t_ratio0();
    t_overflow();
    t_clear_mask();
    t_shrink();
    t_threshold();
    t_same_cycle();
    t_saturate();
    t_encoder();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule